// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a multi-channel event timer. A shared main counter runs outside the block and is presented on `count`, with `tick` high in every clock where that counter has advanced. The channel holds a comparator and, separately, a hidden period. It pulses `expire` for one clock when the counter reaches the comparator. The pulse goes to the interrupt logic, which lies outside this block. In periodic mode each expiry moves the comparator forward by the period, as many times as needed to put it back ahead of the counter. In one-shot mode the channel fires once and then stays quiet until it is armed again.

A narrow mode restricts the comparator, the period and the comparison to the low half of the counter width. Because the comparison in narrow mode uses only the low half, a narrow one-shot channel whose target lies beyond the next low-half rollover raises an extra event at the rollover before the real match. Software loads the comparator and period through two half-width write strobes. A set-value request lets a periodic channel's comparator be written directly. `cmpValue` and `periodValue` expose the stored values for readback.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, and `expire` and `clearPend` are low.
- R2: While armed in one-shot mode, `expire` pulses for one clock in the cycle after the first ticking clock in which the signed difference (comparator minus `count`) is zero or negative over the full width. No further pulse follows until the channel is armed again.
- R3: In narrow mode the test in R2 uses only the low half of the difference, taken as a signed value, so a match is found across a rollover of the low half.
- R4: In periodic mode with a nonzero period, an expiry adds the period to the comparator, one addition per clock, until comparator minus `count` is positive. The whole catch-up produces exactly one `expire` pulse.
- R5: In narrow periodic mode each sum from R4 is truncated to the low half.
- R6: In periodic mode with a period of zero, the channel fires once and does not re-arm.
- R7: In narrow one-shot mode, if the low half of `count` would roll over past all ones before it reaches the comparator, one event fires when the low half reaches all ones and a second event fires at the real match. In full-width mode no rollover event fires.
- R8: A write to either comparator half (`cmpWrLo`, `cmpWrHi`) loads that half of the comparator when the channel is one-shot or a set-value request is pending. In periodic mode a low-half write always loads the low half of the period. A high-half write loads the high half of the period only when no set-value request is pending.
- R9: A pulse on `setValArm` leaves a set-value request pending. Any comparator write, to either half, clears that request.
- R10: A period value written in periodic mode has its most significant bit forced to zero: bit 31 of a low-half write in narrow mode, and bit 63 of a high-half write.
- R11: While `narrow` is high, the upper halves of the comparator and the period read as zero, starting the clock after `narrow` is first seen.
- R12: A rising `enable` arms the channel against the current count, so a comparator already passed fires at the first tick. A comparator write while enabled re-arms the channel. While `enable` is low no `expire` is produced, and a falling `enable` gives a one-clock `clearPend` pulse in the following cycle.
- R13: `expire` is produced only for a clock in which `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Main counter advanced in this clock |
| count | input | CNT_W | Main counter value |
| enable | input | 1 | Channel enable level |
| periodic | input | 1 | 1 selects periodic mode, 0 selects one-shot |
| narrow | input | 1 | 1 selects half-width mode |
| setValArm | input | 1 | Pulse: next comparator write loads the comparator directly |
| cmpWrLo | input | 1 | Write strobe, low half of comparator/period |
| cmpWrHi | input | 1 | Write strobe, high half of comparator/period |
| wrData | input | CNT_W/2 | Write data for either half |
| expire | output | 1 | One-clock expiry event |
| clearPend | output | 1 | One-clock request to clear the pending interrupt |
| cmpValue | output | CNT_W | Stored comparator |
| periodValue | output | CNT_W | Stored hidden period |

## Verification
The hardest condition to reach from the ports is periodic catch-up over several missed periods, because a counter that steps by one never skips past more than one period. The bench drives `count` directly. It holds `tick` low while the channel arms, then presents in a single ticking clock a count that lies several periods beyond the comparator. The comparator must then climb one period per clock to the first value ahead of the count, with only one expiry. The narrow-mode rollover event is reached the same way: the bench starts the count just below a low-half rollover and sets a comparator on the far side of it.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_CATCH,
    ST_DONE
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cmpLoLoad;
    logic cmpHiLoad;
    logic perLoLoad;
    logic perHiLoad;
    logic addPeriod;
    logic armCalc;
    logic clearWrap;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic reached;
    logic wrapArmed;
    logic periodZero;
  } dpStat_t;

endpackage

// File: rtl/evt_timer_dp.sv
`timescale 1ns/1ps
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                narrow,
  input  logic                periodic,
  input  logic [CNT_W-1:0]    count,
  input  logic [CNT_W/2-1:0]  wrData,
  output dpStat_t             stat,
  output logic [CNT_W-1:0]    cmpValue,
  output logic [CNT_W-1:0]    periodValue
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0]  LOW_ONES  = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [HALF_W-1:0] TOP_CLEAR = {1'b0, {(HALF_W-1){1'b1}}};

  logic [CNT_W-1:0]  cmpQ, cmpD, perQ, perD, target, fullDiff;
  logic [HALF_W-1:0] halfDiff, armDiff, armClamped, toWrap;
  logic              wrapQ, wrapD, wrapNeeded;

  // wrap-aware reach test against either the rollover point or the comparator
  always_comb begin
    target   = wrapQ ? LOW_ONES : cmpQ;
    fullDiff = target - count;
    halfDiff = fullDiff[HALF_W-1:0];
    if (narrow) stat.reached = halfDiff[HALF_W-1] || (halfDiff == '0);
    else        stat.reached = fullDiff[CNT_W-1]  || (fullDiff == '0);
    stat.wrapArmed  = wrapQ;
    stat.periodZero = (perQ == '0);
  end

  // rollover check made when the channel is armed
  always_comb begin
    armDiff    = cmpQ[HALF_W-1:0] - count[HALF_W-1:0];
    armClamped = armDiff[HALF_W-1] ? '0 : armDiff;
    toWrap     = ~count[HALF_W-1:0];
    wrapNeeded = narrow && !periodic && (toWrap < armClamped);
  end

  always_comb begin
    cmpD = cmpQ;
    perD = perQ;
    if (ctl.cmpLoLoad) cmpD[HALF_W-1:0]     = wrData;
    if (ctl.cmpHiLoad) cmpD[CNT_W-1:HALF_W] = wrData;
    if (ctl.perLoLoad) perD[HALF_W-1:0]     = narrow ? (wrData & TOP_CLEAR) : wrData;
    if (ctl.perHiLoad) perD[CNT_W-1:HALF_W] = wrData & TOP_CLEAR;
    if (ctl.addPeriod && !ctl.cmpLoLoad && !ctl.cmpHiLoad) cmpD = cmpQ + perQ;
    if (narrow) begin
      cmpD[CNT_W-1:HALF_W] = '0;
      perD[CNT_W-1:HALF_W] = '0;
    end
    if (ctl.armCalc)        wrapD = wrapNeeded;
    else if (ctl.clearWrap) wrapD = 1'b0;
    else                    wrapD = wrapQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ  <= '1;
      perQ  <= '0;
      wrapQ <= 1'b0;
    end else begin
      cmpQ  <= cmpD;
      perQ  <= perD;
      wrapQ <= wrapD;
    end
  end

  assign cmpValue    = cmpQ;
  assign periodValue = perQ;

endmodule

// File: rtl/evt_timer_ctrl.sv
`timescale 1ns/1ps
module evt_timer_ctrl
  import evt_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    enable,
  input  logic    periodic,
  input  logic    setValArm,
  input  logic    cmpWrLo,
  input  logic    cmpWrHi,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    expire,
  output logic    clearPend
);
  chanState_t stateQ, stateD;
  logic enPrev, setValQ, expireQ, clearPendQ;
  logic anyWr, loadCmp, fire;

  always_comb begin
    anyWr   = cmpWrLo || cmpWrHi;
    loadCmp = !periodic || setValQ;
    ctl           = '0;
    ctl.cmpLoLoad = cmpWrLo && loadCmp;
    ctl.cmpHiLoad = cmpWrHi && loadCmp;
    ctl.perLoLoad = cmpWrLo && periodic;
    ctl.perHiLoad = cmpWrHi && periodic && !setValQ;
    fire   = 1'b0;
    stateD = stateQ;
    if (!enable) begin
      stateD        = ST_IDLE;
      ctl.clearWrap = 1'b1;
    end else if (!enPrev || anyWr) begin
      stateD = ST_ARM;
    end else begin
      case (stateQ)
        ST_IDLE: stateD = ST_ARM;
        ST_ARM: begin
          ctl.armCalc = 1'b1;
          stateD      = ST_WAIT;
        end
        ST_WAIT: begin
          if (tick && stat.reached) begin
            fire = 1'b1;
            if (stat.wrapArmed)                    ctl.clearWrap = 1'b1;
            else if (periodic && !stat.periodZero) stateD = ST_CATCH;
            else                                   stateD = ST_DONE;
          end
        end
        ST_CATCH: begin
          if (stat.reached) ctl.addPeriod = 1'b1;
          else              stateD = ST_WAIT;
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      enPrev     <= 1'b0;
      setValQ    <= 1'b0;
      expireQ    <= 1'b0;
      clearPendQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      enPrev     <= enable;
      if (anyWr)          setValQ <= 1'b0;
      else if (setValArm) setValQ <= 1'b1;
      expireQ    <= fire;
      clearPendQ <= enPrev && !enable;
    end
  end

  assign expire    = expireQ;
  assign clearPend = clearPendQ;

endmodule

// File: rtl/evt_timer_channel.sv
`timescale 1ns/1ps
module evt_timer_channel
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [CNT_W-1:0]   count,
  input  logic               enable,
  input  logic               periodic,
  input  logic               narrow,
  input  logic               setValArm,
  input  logic               cmpWrLo,
  input  logic               cmpWrHi,
  input  logic [CNT_W/2-1:0] wrData,
  output logic               expire,
  output logic               clearPend,
  output logic [CNT_W-1:0]   cmpValue,
  output logic [CNT_W-1:0]   periodValue
);
  dpCtl_t  ctl;
  dpStat_t stat;

  evt_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .periodic(periodic),
    .setValArm(setValArm), .cmpWrLo(cmpWrLo), .cmpWrHi(cmpWrHi),
    .stat(stat), .ctl(ctl), .expire(expire), .clearPend(clearPend)
  );

  evt_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .narrow(narrow), .periodic(periodic),
    .count(count), .wrData(wrData), .stat(stat),
    .cmpValue(cmpValue), .periodValue(periodValue)
  );

endmodule

// File: rtl/evt_timer_channel_chk.sv
`timescale 1ns/1ps
module evt_timer_channel_chk #(
  parameter int CNT_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               enable,
  input logic               periodic,
  input logic               narrow,
  input logic               cmpWrLo,
  input logic [CNT_W/2-1:0] wrData,
  input logic               expire,
  input logic               clearPend,
  input logic [CNT_W-1:0]   cmpValue,
  input logic [CNT_W-1:0]   periodValue
);
  localparam int HALF_W = CNT_W / 2;

  assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !expire);

  assert_clear_on_disable_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |=> clearPend);

  assert_narrow_upper_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    narrow |=> (cmpValue[CNT_W-1:HALF_W] == '0) && (periodValue[CNT_W-1:HALF_W] == '0));

  assert_tick_gated_R13: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> $past(tick));

  assert_oneshot_lo_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWrLo && !periodic) |=> (cmpValue[HALF_W-1:0] == $past(wrData)));

  assert_period_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!periodic && !narrow) |=> $stable(periodValue));

endmodule

bind evt_timer_channel evt_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .periodic(periodic),
  .narrow(narrow), .cmpWrLo(cmpWrLo), .wrData(wrData), .expire(expire),
  .clearPend(clearPend), .cmpValue(cmpValue), .periodValue(periodValue)
);

// File: tb/evt_timer_channel_bench.sv
`timescale 1ns/1ps
module evt_timer_channel_bench;
  localparam int CNT_W = 64;

  logic clk = 1'b0;
  logic rstN, tick, enable, periodic, narrow, setValArm, cmpWrLo, cmpWrHi;
  logic [CNT_W-1:0] count;
  logic [31:0] wrData;
  logic expire, clearPend;
  logic [CNT_W-1:0] cmpValue, periodValue;

  always #2.5 clk = ~clk;

  evt_timer_channel #(.CNT_W(CNT_W)) u_evt_timer_channel (
    .clk(clk), .rstN(rstN), .tick(tick), .count(count), .enable(enable),
    .periodic(periodic), .narrow(narrow), .setValArm(setValArm),
    .cmpWrLo(cmpWrLo), .cmpWrHi(cmpWrHi), .wrData(wrData),
    .expire(expire), .clearPend(clearPend),
    .cmpValue(cmpValue), .periodValue(periodValue)
  );

  typedef struct packed {
    logic        per;
    logic        sv;
    logic        nar;
    logic        hi;
    logic [31:0] data;
    logic [63:0] expCmp;
    logic [63:0] expPer;
  } wrVec_t;

  // write-routing vectors, each applied from the reset state
  localparam wrVec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h12345678, 64'hFFFFFFFF_12345678, 64'h0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'hAAAA5555, 64'hAAAA5555_FFFFFFFF, 64'h0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h80000010, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_80000010},
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h80000010, 64'h00000000_FFFFFFFF, 64'h00000000_00000010},
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h7FFFFFFF_00000000},
    '{1'b1, 1'b1, 1'b0, 1'b1, 32'h11112222, 64'h11112222_FFFFFFFF, 64'h0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h00000100, 64'hFFFFFFFF_00000100, 64'h00000000_00000100},
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h00000012, 64'h00000000_FFFFFFFF, 64'h0}
  };

  int nChecks = 0;
  int nFails  = 0;
  int nEv;
  logic [63:0] evAt [4];
  logic [63:0] cnt;
  logic [63:0] tgt;

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tick = 1'b0; enable = 1'b0; periodic = 1'b0; narrow = 1'b0;
    setValArm = 1'b0; cmpWrLo = 1'b0; cmpWrHi = 1'b0; wrData = '0;
    cnt = '0; count = '0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic wrLo(input logic [31:0] d);
    wrData = d; cmpWrLo = 1'b1; cyc(); cmpWrLo = 1'b0;
  endtask

  task automatic wrHi(input logic [31:0] d);
    wrData = d; cmpWrHi = 1'b1; cyc(); cmpWrHi = 1'b0;
  endtask

  task automatic armSv();
    setValArm = 1'b1; cyc(); setValArm = 1'b0;
  endtask

  // step the counter by one per clock, recording the count of each expiry
  task automatic advance(input int n);
    nEv = 0;
    for (int i = 0; i < n; i++) begin
      count = cnt; tick = 1'b1;
      cyc();
      if (expire) begin
        if (nEv < 4) evAt[nEv] = cnt;
        nEv++;
      end
      cnt = cnt + 1;
    end
    tick = 1'b0; count = cnt;
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8 R10 R11: write routing table
    for (int v = 0; v < 8; v++) begin
      doReset();
      periodic = VECS[v].per; narrow = VECS[v].nar;
      cyc();
      if (VECS[v].sv) armSv();
      if (VECS[v].hi) wrHi(VECS[v].data); else wrLo(VECS[v].data);
      cyc();
      check($sformatf("R8 vec%0d comparator", v), cmpValue, VECS[v].expCmp);
      check($sformatf("R10 vec%0d period", v), periodValue, VECS[v].expPer);
    end

    // R1 reset state
    doReset();
    check("R1 comparator", cmpValue, '1);
    check("R1 period", periodValue, '0);
    check("R1 expire", {63'd0, expire}, 64'd0);
    check("R1 clearPend", {63'd0, clearPend}, 64'd0);

    // R2 one-shot full width
    cnt = 100; count = 100;
    wrLo(110); wrHi(0);
    enable = 1'b1;
    advance(30);
    check("R2 one event", nEv, 1);
    check("R2 event count", evAt[0], 110);

    // R12 disable: clear pulse, no events while off
    enable = 1'b0;
    cyc();
    check("R12 clearPend pulse", {63'd0, clearPend}, 64'd1);
    cyc();
    check("R12 clearPend drops", {63'd0, clearPend}, 64'd0);
    wrLo(cnt[31:0] + 5);
    advance(20);
    check("R12 quiet while disabled", nEv, 0);

    // R12 enabling with comparator already passed fires at once
    enable = 1'b1;
    advance(5);
    check("R12 arm on passed comparator", nEv, 1);
    // R12 re-arm by a write while enabled
    tgt = cnt + 10;
    wrLo(tgt[31:0]);
    advance(20);
    check("R12 rearm by write", nEv, 1);
    check("R12 rearm count", evAt[0], tgt);

    // R9 set-value cleared by any write; R4 periodic
    doReset();
    periodic = 1'b1;
    armSv(); wrHi(0);
    wrLo(1010);
    check("R9 write after clear leaves comparator", cmpValue, 64'h00000000_FFFFFFFF);
    armSv(); wrLo(1010);
    wrLo(20);
    check("R8 periodic comparator", cmpValue, 1010);
    check("R8 periodic period", periodValue, 20);
    cnt = 1000; count = 1000;
    enable = 1'b1;
    advance(70);
    check("R4 periodic events", nEv, 3);
    check("R4 event 0", evAt[0], 1010);
    check("R4 event 1", evAt[1], 1030);
    check("R4 event 2", evAt[2], 1050);
    check("R4 final comparator", cmpValue, 1070);

    // R4 catch-up over several missed periods
    doReset();
    periodic = 1'b1;
    armSv(); wrHi(0);
    armSv(); wrLo(50);
    wrLo(10);
    enable = 1'b1;
    repeat (3) cyc();
    count = 95; tick = 1'b1;
    cyc();
    check("R4 catch-up expiry", {63'd0, expire}, 64'd1);
    tick = 1'b0;
    nEv = 0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      if (expire) nEv++;
    end
    check("R4 single pulse over catch-up", nEv, 0);
    check("R4 caught-up comparator", cmpValue, 100);

    // R6 periodic with zero period
    doReset();
    periodic = 1'b1;
    armSv(); wrHi(0);
    armSv(); wrLo(30);
    wrLo(0);
    enable = 1'b1;
    advance(100);
    check("R6 zero period fires once", nEv, 1);
    check("R6 event count", evAt[0], 30);

    // R3 R5 narrow periodic across rollover
    doReset();
    narrow = 1'b1; periodic = 1'b1;
    cyc();
    armSv(); wrLo(32'hFFFFFFF0);
    check("R10 narrow period top bit", periodValue, 64'h7FFFFFF0);
    wrLo(32'h20);
    cnt = 64'hFFFFFFE0; count = cnt;
    enable = 1'b1;
    advance(80);
    check("R3 narrow events", nEv, 2);
    check("R3 event 0", evAt[0], 64'hFFFFFFF0);
    check("R5 event 1", evAt[1], 64'h1_00000010);
    check("R5 truncated comparator", cmpValue, 64'h30);

    // R7 narrow one-shot rollover event
    doReset();
    narrow = 1'b1;
    cyc();
    wrLo(32'h10);
    cnt = 64'hFFFFFFF0; count = cnt;
    enable = 1'b1;
    advance(48);
    check("R7 two events", nEv, 2);
    check("R7 rollover event", evAt[0], 64'hFFFFFFFF);
    check("R7 match event", evAt[1], 64'h1_00000010);

    // R7 full width has no rollover event
    doReset();
    wrHi(1); wrLo(32'h10);
    cnt = 64'hFFFFFFF0; count = cnt;
    enable = 1'b1;
    advance(48);
    check("R7 wide single event", nEv, 1);
    check("R7 wide event count", evAt[0], 64'h1_00000010);

    // R13 no expiry without tick
    doReset();
    wrHi(0); wrLo(5);
    cnt = 10; count = 10;
    enable = 1'b1;
    nEv = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (expire) nEv++;
    end
    check("R13 held without tick", nEv, 0);
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    check("R13 fires on tick", {63'd0, expire}, 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule